// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank Legality Tracking

This block watches the control pins of a synchronous DRAM on every rising clock edge, turns the pin pattern into a command code, and judges that command against the state of the bank it addresses. It keeps a small state machine for each of four banks (idle, opening a row, row open, bursting, bursting with auto-precharge, closing, refreshing, mode setting, self-refresh). The timing intervals that move a bank between states are given as clock-cycle parameters.

It is meant to sit beside a memory controller or a memory model as a protocol monitor. Each cycle it reports the decoded command, whether that command was permitted, the two A10 qualifiers and the packed state of every bank. An illegal command is reported and has no effect on any bank.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With sel_n high the command code is DESELECT (0). With sel_n low and the RAS, CAS and WE strobes all high, the code is NOP (1). Both are always legal and have no effect on any bank.
- R2: When clk_en_prev is high and sel_n is low, the RAS/CAS/WE strobes (active low) decode as follows: L,H,H is ACT (2); H,L,H is READ (3); H,L,L is WRITE (4); L,H,L is PRE (5); H,H,L is burst stop (6); L,L,H with clk_en_now high is REFRESH (7); L,L,H with clk_en_now low is SELF-REFRESH ENTRY (9); L,L,L is MODE SET (8). Codes 10 (self-refresh exit) and 11 (hold) are described in R9 and R10. All outputs are registered and show the command sampled at the same edge.
- R3: auto_pre_o is high exactly when the command is READ or WRITE with ap_bit high. pre_all_o is high exactly when the command is PRE with ap_bit high. The two are never high together.
- R4: For an idle bank, ACT is legal and the bank enters row-opening. READ, WRITE and burst stop are illegal. A single-bank PRE is legal and leaves the bank idle.
- R5: REFRESH, MODE SET and SELF-REFRESH ENTRY are legal only when every bank is idle, and are illegal otherwise. REFRESH puts all banks in refreshing for T_RC cycles, and MODE SET puts them in mode setting for T_RSC cycles; after that interval they return to idle.
- R6: A row-opening bank becomes row-open after T_RCD cycles. A closing bank becomes idle after T_RP cycles. While a bank is in either interval, ACT, READ, WRITE and burst stop to it are illegal. PRE is illegal to a row-opening bank and is legal with no effect on a closing bank.
- R7: For a bank that is row-open or bursting, READ or WRITE is legal and starts a burst of T_BURST cycles, restarting any burst in progress; after the burst the bank is row-open again. Burst stop returns a bursting bank to row-open. PRE starts closing the bank for T_RP cycles. ACT is illegal.
- R8: READ or WRITE with ap_bit high starts an auto-precharge burst. During it, ACT, READ, WRITE, PRE and burst stop to that bank are illegal. At the end of the burst the bank closes for T_RP cycles and then becomes idle.
- R9: A legal SELF-REFRESH ENTRY puts all banks in self-refresh. The banks stay there while clk_en_prev is low and clk_en_now is low (hold code 11). clk_en_prev low with clk_en_now high decodes as SELF-REFRESH EXIT (10), which is legal and puts all banks in refreshing for T_RC cycles, after which they become idle.
- R10: With clk_en_prev low outside self-refresh, the pins are not decoded. The code is hold (11), which is legal, and bank states change only by their running intervals.
- R11: An illegal command changes no bank state. Running intervals continue as if a NOP had been given.
- R12: bank_state_o holds bank i in bits [4i+3:4i], with the codes idle 0, row-opening 1, row-open 2, reading 3, writing 4, reading with auto-precharge 5, writing with auto-precharge 6, closing 7, refreshing 8, mode setting 9 and self-refresh 10. Reset gives all banks idle, command DESELECT, legal_o high and both qualifiers low.
- R13: PRE with ap_bit high is legal only if no bank is row-opening, bursting with auto-precharge, refreshing, mode setting or in self-refresh. It moves every row-open or bursting bank to closing and leaves idle and closing banks as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | RAS strobe, active low |
| col_strobe_n | input | 1 | CAS strobe, active low |
| wr_en_n | input | 1 | WE strobe, active low |
| clk_en_prev | input | 1 | Clock enable as sampled in the previous cycle |
| clk_en_now | input | 1 | Clock enable in the current cycle |
| bank_sel | input | BA_W | Bank address |
| ap_bit | input | 1 | Address bit 10: auto-precharge / precharge-all qualifier |
| cmd_o | output | 4 | Decoded command code (R2) |
| legal_o | output | 1 | Command was legal in the addressed bank state |
| auto_pre_o | output | 1 | READ/WRITE with auto-precharge |
| pre_all_o | output | 1 | PRE applied to all banks |
| bank_state_o | output | 4*NUM_BANKS | Packed bank state codes (R12) |

## Verification
The bench aims at commands that arrive on the last cycle of an interval. For example, a READ on the final burst cycle must restart the burst. A design that let the timer expiry win would report the bank row-open one burst too early. Precharge-all is driven with a mix of bank states. A design that checked only the addressed bank would accept it while another bank is still opening a row. Self-refresh is entered, held and left through the clock-enable pair. A design that decoded pins while the clock enable was low would treat held pins as new commands. Refresh and mode set are issued while one bank is open, to show they are rejected and leave every bank unchanged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   localparam int CMD_W = 4;
   localparam int ST_W  = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_DESEL    = 4'd0,
      CMD_NOP      = 4'd1,
      CMD_ACT      = 4'd2,
      CMD_READ     = 4'd3,
      CMD_WRITE    = 4'd4,
      CMD_PRE      = 4'd5,
      CMD_BST      = 4'd6,
      CMD_REF      = 4'd7,
      CMD_MRS      = 4'd8,
      CMD_SREF_IN  = 4'd9,
      CMD_SREF_OUT = 4'd10,
      CMD_HOLD     = 4'd11
   } cmd_e;

   typedef enum logic [ST_W-1:0] {
      BK_IDLE        = 4'd0,
      BK_OPENING     = 4'd1,
      BK_ACTIVE      = 4'd2,
      BK_READING     = 4'd3,
      BK_WRITING     = 4'd4,
      BK_READ_AP     = 4'd5,
      BK_WRITE_AP    = 4'd6,
      BK_CLOSING     = 4'd7,
      BK_REFRESHING  = 4'd8,
      BK_MODE_WAIT   = 4'd9,
      BK_SELF_REF    = 4'd10
   } bank_e;

   // Row open, possibly bursting without auto-precharge.
   function automatic logic row_usable(input logic [ST_W-1:0] s);
      return (s == BK_ACTIVE) || (s == BK_READING) || (s == BK_WRITING);
   endfunction

   // States in which a precharge request is accepted.
   function automatic logic close_ok(input logic [ST_W-1:0] s);
      return row_usable(s) || (s == BK_IDLE) || (s == BK_CLOSING);
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic sel_n,
   input  logic row_strobe_n,
   input  logic col_strobe_n,
   input  logic wr_en_n,
   input  logic clk_en_prev,
   input  logic clk_en_now,
   input  logic in_self_ref,
   output cmd_e cmd
);

   logic [2:0] strobes;
   assign strobes = {row_strobe_n, col_strobe_n, wr_en_n};

   always_comb begin
      cmd = CMD_NOP;
      if (!clk_en_prev) begin
         // Clock suspended: pins are not decoded.
         cmd = (in_self_ref && clk_en_now) ? CMD_SREF_OUT : CMD_HOLD;
      end else if (sel_n) begin
         cmd = CMD_DESEL;
      end else begin
         case (strobes)
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_READ;
            3'b100:  cmd = CMD_WRITE;
            3'b010:  cmd = CMD_PRE;
            3'b110:  cmd = CMD_BST;
            3'b001:  cmd = clk_en_now ? CMD_REF : CMD_SREF_IN;
            default: cmd = CMD_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
)(
   input  cmd_e                               cmd,
   input  logic [BA_W-1:0]                    bank_sel,
   input  logic                               ap_bit,
   input  logic [NUM_BANKS-1:0][ST_W-1:0]     st,
   output logic                               legal,
   output logic                               all_idle
);

   logic [NUM_BANKS-1:0] idle_v;
   logic [NUM_BANKS-1:0] close_v;
   logic [ST_W-1:0]      sel_st;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_flags
      assign idle_v[g]  = (st[g] == BK_IDLE);
      assign close_v[g] = close_ok(st[g]);
   end

   assign all_idle = &idle_v;
   assign sel_st   = st[bank_sel];

   always_comb begin
      legal = 1'b1;
      case (cmd)
         CMD_REF, CMD_MRS, CMD_SREF_IN: legal = all_idle;
         CMD_ACT:                       legal = (sel_st == BK_IDLE);
         CMD_READ, CMD_WRITE, CMD_BST:  legal = row_usable(sel_st);
         CMD_PRE:                       legal = ap_bit ? (&close_v) : close_ok(sel_st);
         default:                       legal = 1'b1;
      endcase
   end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
   import sdcmd_pkg::*;
#(
   parameter int T_RCD   = 2,
   parameter int T_RP    = 2,
   parameter int T_RC    = 6,
   parameter int T_RSC   = 2,
   parameter int T_BURST = 4,
   parameter int CNT_W   = 3,
   parameter int BA_W    = 2,
   parameter int IDX     = 0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  cmd_e            cmd,
   input  logic            legal,
   input  logic [BA_W-1:0] bank_sel,
   input  logic            ap_bit,
   output logic [ST_W-1:0] state
);

   localparam logic [BA_W-1:0]  MY_BA    = BA_W'(IDX);
   localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD);
   localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] LD_RC    = CNT_W'(T_RC);
   localparam logic [CNT_W-1:0] LD_RSC   = CNT_W'(T_RSC);
   localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(T_BURST);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   bank_e            st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             hit, timed, bursting;

   assign hit      = (bank_sel == MY_BA);
   assign bursting = (st_q == BK_READING) || (st_q == BK_WRITING);

   always_comb begin
      case (st_q)
         BK_OPENING, BK_READING, BK_WRITING, BK_READ_AP, BK_WRITE_AP,
         BK_CLOSING, BK_REFRESHING, BK_MODE_WAIT: timed = 1'b1;
         default:                                  timed = 1'b0;
      endcase
   end

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      // Interval bookkeeping first; a legal command below overrides it.
      if (timed) begin
         if (cnt_q == ONE) begin
            case (st_q)
               BK_OPENING, BK_READING, BK_WRITING: st_d = BK_ACTIVE;
               BK_READ_AP, BK_WRITE_AP: begin
                  st_d  = BK_CLOSING;
                  cnt_d = LD_RP;
               end
               default: st_d = BK_IDLE;
            endcase
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
      if (legal) begin
         case (cmd)
            CMD_REF, CMD_SREF_OUT: begin
               st_d  = BK_REFRESHING;
               cnt_d = LD_RC;
            end
            CMD_MRS: begin
               st_d  = BK_MODE_WAIT;
               cnt_d = LD_RSC;
            end
            CMD_SREF_IN: st_d = BK_SELF_REF;
            CMD_ACT: if (hit) begin
               st_d  = BK_OPENING;
               cnt_d = LD_RCD;
            end
            CMD_READ: if (hit) begin
               st_d  = ap_bit ? BK_READ_AP : BK_READING;
               cnt_d = LD_BURST;
            end
            CMD_WRITE: if (hit) begin
               st_d  = ap_bit ? BK_WRITE_AP : BK_WRITING;
               cnt_d = LD_BURST;
            end
            CMD_PRE: if ((hit || ap_bit) && row_usable(st_q)) begin
               st_d  = BK_CLOSING;
               cnt_d = LD_RP;
            end
            CMD_BST: if (hit && bursting) st_d = BK_ACTIVE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BK_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state = st_q;

   AST_ACT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (legal && cmd == CMD_ACT && hit) |-> (st_q == BK_IDLE)) else $error("ACT accepted on non-idle bank"); // R4

   AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_IDLE && $past(st_q) != BK_IDLE) |->
      ($past(st_q) == BK_CLOSING || $past(st_q) == BK_REFRESHING || $past(st_q) == BK_MODE_WAIT))
      else $error("bank became idle from wrong state"); // R6

   AST_ACTIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_ACTIVE && $past(st_q) != BK_ACTIVE) |->
      ($past(st_q) == BK_OPENING || $past(st_q) == BK_READING || $past(st_q) == BK_WRITING))
      else $error("row opened from wrong state"); // R7

   AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st_q) == BK_READ_AP || $past(st_q) == BK_WRITE_AP) &&
       st_q != BK_READ_AP && st_q != BK_WRITE_AP) |-> (st_q == BK_CLOSING))
      else $error("auto-precharge burst did not close bank"); // R8

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = $clog2(NUM_BANKS),
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RC      = 6,
   parameter int T_RSC     = 2,
   parameter int T_BURST   = 4
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel_n,
   input  logic                        row_strobe_n,
   input  logic                        col_strobe_n,
   input  logic                        wr_en_n,
   input  logic                        clk_en_prev,
   input  logic                        clk_en_now,
   input  logic [BA_W-1:0]             bank_sel,
   input  logic                        ap_bit,
   output logic [CMD_W-1:0]            cmd_o,
   output logic                        legal_o,
   output logic                        auto_pre_o,
   output logic                        pre_all_o,
   output logic [NUM_BANKS*ST_W-1:0]   bank_state_o
);

   localparam int T_MAX = max_of(max_of(max_of(T_RCD, T_RP), max_of(T_RC, T_RSC)), T_BURST);
   localparam int CNT_W = $clog2(T_MAX + 1);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (BA_W != $clog2(NUM_BANKS)) begin : g_bad_ba
      $error("BA_W must equal clog2(NUM_BANKS)");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RC < 1 || T_RSC < 1 || T_BURST < 1) begin : g_bad_t
      $error("every interval parameter must be at least one cycle");
   end

   logic [NUM_BANKS-1:0][ST_W-1:0] st;
   cmd_e                            cmd_now;
   logic                            legal_now, all_idle, in_self_ref;
   cmd_e                            cmd_q;
   logic                            legal_q, ap_q, pa_q;

   assign in_self_ref = (st[0] == BK_SELF_REF);

   sdcmd_decode u_decode (
      .sel_n        (sel_n),
      .row_strobe_n (row_strobe_n),
      .col_strobe_n (col_strobe_n),
      .wr_en_n      (wr_en_n),
      .clk_en_prev  (clk_en_prev),
      .clk_en_now   (clk_en_now),
      .in_self_ref  (in_self_ref),
      .cmd          (cmd_now)
   );

   sdcmd_judge #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_judge (
      .cmd      (cmd_now),
      .bank_sel (bank_sel),
      .ap_bit   (ap_bit),
      .st       (st),
      .legal    (legal_now),
      .all_idle (all_idle)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdcmd_bank #(
         .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RSC(T_RSC),
         .T_BURST(T_BURST), .CNT_W(CNT_W), .BA_W(BA_W), .IDX(b)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd      (cmd_now),
         .legal    (legal_now),
         .bank_sel (bank_sel),
         .ap_bit   (ap_bit),
         .state    (st[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_DESEL;
         legal_q <= 1'b1;
         ap_q    <= 1'b0;
         pa_q    <= 1'b0;
      end else begin
         cmd_q   <= cmd_now;
         legal_q <= legal_now;
         ap_q    <= ((cmd_now == CMD_READ) || (cmd_now == CMD_WRITE)) && ap_bit;
         pa_q    <= (cmd_now == CMD_PRE) && ap_bit;
      end
   end

   assign cmd_o        = cmd_q;
   assign legal_o      = legal_q;
   assign auto_pre_o   = ap_q;
   assign pre_all_o    = pa_q;
   assign bank_state_o = st;

   logic [NUM_BANKS-1:0] sref_v;
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sref
      assign sref_v[b] = (st[b] == BK_SELF_REF);
   end

   AST_QUAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({auto_pre_o, pre_all_o})) else $error("both qualifiers high"); // R3

   AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_o && (cmd_o == CMD_REF || cmd_o == CMD_MRS || cmd_o == CMD_SREF_IN)) |-> $past(all_idle))
      else $error("global command accepted with a busy bank"); // R5

   AST_SREF_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (sref_v != '0) |-> (&sref_v)) else $error("banks disagree on self-refresh"); // R9

   AST_ILLEGAL_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal_o && cmd_o == CMD_ACT) |-> ($countones(sref_v) == 0 || &sref_v))
      else $error("illegal ACT disturbed banks"); // R11

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

   localparam int NB = 4, TRCD = 2, TRP = 2, TRC = 6, TRSC = 2, TBL = 4;
   localparam int C_DESEL = 0, C_NOP = 1, C_ACT = 2, C_READ = 3, C_WRITE = 4, C_PRE = 5,
                  C_BST = 6, C_REF = 7, C_MRS = 8, C_SIN = 9, C_SOUT = 10, C_HOLD = 11;
   localparam int S_IDLE = 0, S_OPEN = 1, S_ACTV = 2, S_RD = 3, S_WR = 4, S_RDA = 5,
                  S_WRA = 6, S_CLS = 7, S_REF = 8, S_MRS = 9, S_SREF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, we_n = 1'b1;
   logic ckp = 1'b1, ckc = 1'b1, ap = 1'b0;
   logic [1:0] bsel = 2'd0;
   logic [3:0] cmd_o;
   logic legal_o, auto_pre_o, pre_all_o;
   logic [15:0] bank_state_o;

   int m_st[NB];
   int m_cnt[NB];
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   sdram_cmd_tracker #(.NUM_BANKS(NB), .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC),
                       .T_RSC(TRSC), .T_BURST(TBL)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_strobe_n(row_n), .col_strobe_n(col_n),
      .wr_en_n(we_n), .clk_en_prev(ckp), .clk_en_now(ckc), .bank_sel(bsel), .ap_bit(ap),
      .cmd_o(cmd_o), .legal_o(legal_o), .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o),
      .bank_state_o(bank_state_o));

   function automatic int f_dec(bit cs, bit r, bit c, bit w, bit kp, bit kc);
      if (!kp) return (m_st[0] == S_SREF && kc) ? C_SOUT : C_HOLD;
      if (cs) return C_DESEL;
      case ({r, c, w})
         3'b111: return C_NOP;
         3'b011: return C_ACT;
         3'b101: return C_READ;
         3'b100: return C_WRITE;
         3'b010: return C_PRE;
         3'b110: return C_BST;
         3'b001: return kc ? C_REF : C_SIN;
         default: return C_MRS;
      endcase
   endfunction

   function automatic bit open_row(int s);
      return s == S_ACTV || s == S_RD || s == S_WR;
   endfunction

   function automatic bit f_legal(int c, int b, bit a);
      bit idle_all = 1'b1, pre_all_ok = 1'b1;
      for (int i = 0; i < NB; i++) begin
         if (m_st[i] != S_IDLE) idle_all = 1'b0;
         if (!(open_row(m_st[i]) || m_st[i] == S_IDLE || m_st[i] == S_CLS)) pre_all_ok = 1'b0;
      end
      case (c)
         C_REF, C_MRS, C_SIN: return idle_all;
         C_ACT: return m_st[b] == S_IDLE;
         C_READ, C_WRITE, C_BST: return open_row(m_st[b]);
         C_PRE: return a ? pre_all_ok
                         : (open_row(m_st[b]) || m_st[b] == S_IDLE || m_st[b] == S_CLS);
         default: return 1'b1;
      endcase
   endfunction

   task automatic m_advance(int c, bit lg, int b, bit a);
      for (int i = 0; i < NB; i++) begin
         int s, n;
         s = m_st[i];
         n = m_cnt[i];
         if (s inside {S_OPEN, S_RD, S_WR, S_RDA, S_WRA, S_CLS, S_REF, S_MRS}) begin
            if (n == 1) begin
               if (s == S_OPEN || s == S_RD || s == S_WR) s = S_ACTV;
               else if (s == S_RDA || s == S_WRA) begin s = S_CLS; n = TRP; end
               else s = S_IDLE;
            end else n--;
         end
         if (lg) begin
            if (c == C_REF || c == C_SOUT) begin s = S_REF; n = TRC; end
            else if (c == C_MRS) begin s = S_MRS; n = TRSC; end
            else if (c == C_SIN) s = S_SREF;
            else if (c == C_ACT && i == b) begin s = S_OPEN; n = TRCD; end
            else if (c == C_READ && i == b) begin s = a ? S_RDA : S_RD; n = TBL; end
            else if (c == C_WRITE && i == b) begin s = a ? S_WRA : S_WR; n = TBL; end
            else if (c == C_PRE && (i == b || a) && open_row(m_st[i])) begin s = S_CLS; n = TRP; end
            else if (c == C_BST && i == b && (m_st[i] == S_RD || m_st[i] == S_WR)) s = S_ACTV;
         end
         m_st[i] = s;
         m_cnt[i] = n;
      end
   endtask

   function automatic string tag_of(int c);
      case (c)
         C_DESEL, C_NOP: return "R1";
         C_ACT: return "R4";
         C_READ, C_WRITE, C_BST: return "R7";
         C_PRE: return "R13";
         C_REF, C_MRS: return "R5";
         C_SIN, C_SOUT: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [22:0] act, logic [22:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called right after a falling edge; returns at the next falling edge.
   task automatic step(bit cs, bit r, bit c, bit w, bit kp, bit kc, int b, bit a, string tag);
      int e_cmd;
      bit e_leg, e_ap, e_pa;
      logic [15:0] e_st;
      logic [22:0] e_vec, a_vec;
      sel_n = cs; row_n = r; col_n = c; we_n = w; ckp = kp; ckc = kc; bsel = 2'(b); ap = a;
      e_cmd = f_dec(cs, r, c, w, kp, kc);
      e_leg = f_legal(e_cmd, b, a);
      e_ap = (e_cmd == C_READ || e_cmd == C_WRITE) && a;
      e_pa = (e_cmd == C_PRE) && a;
      @(posedge clk);
      m_advance(e_cmd, e_leg, b, a);
      @(negedge clk);
      for (int i = 0; i < NB; i++) e_st[4*i +: 4] = 4'(m_st[i]);
      e_vec = {4'(e_cmd), e_leg, e_ap, e_pa, e_st};
      a_vec = {cmd_o, legal_o, auto_pre_o, pre_all_o, bank_state_o};
      check(a_vec === e_vec, (tag == "") ? tag_of(e_cmd) : tag, a_vec, e_vec);
   endtask

   task automatic cmdx(bit r, bit c, bit w, int b, bit a, string tag);
      step(1'b0, r, c, w, 1'b1, 1'b1, b, a, tag);
   endtask

   task automatic nops(int n, string tag);
      for (int k = 0; k < n; k++) cmdx(1'b1, 1'b1, 1'b1, 0, 1'b0, tag);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) begin m_st[i] = S_IDLE; m_cnt[i] = 0; end
      void'($urandom(32'h5EED_0C1D));
      repeat (3) @(negedge clk);
      check({cmd_o, legal_o, auto_pre_o, pre_all_o, bank_state_o} === {4'd0, 1'b1, 1'b0, 1'b0, 16'h0},
            "R12", {cmd_o, legal_o, auto_pre_o, pre_all_o, bank_state_o}, {4'd0, 3'b100, 16'h0});
      rst_n = 1'b1;
      // R1 / R2 basic decode
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R1");
      nops(1, "R1");
      // R4 idle bank
      cmdx(1'b1, 1'b0, 1'b1, 0, 1'b0, "R4");   // READ illegal
      cmdx(1'b1, 1'b1, 1'b0, 0, 1'b0, "R4");   // BST illegal
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b0, "R4");   // PRE legal, stays idle
      cmdx(1'b0, 1'b1, 1'b1, 0, 1'b0, "R4");   // ACT
      cmdx(1'b1, 1'b0, 1'b1, 0, 1'b0, "R6");   // READ while opening
      nops(1, "R6");
      // R5 global commands with an open bank
      cmdx(1'b0, 1'b0, 1'b1, 1, 1'b0, "R5");
      cmdx(1'b0, 1'b0, 1'b0, 1, 1'b0, "R5");
      cmdx(1'b0, 1'b1, 1'b1, 0, 1'b0, "R11");  // ACT to open bank: illegal
      // R7 bursts
      cmdx(1'b1, 1'b0, 1'b1, 0, 1'b0, "R7");
      nops(3, "R7");
      cmdx(1'b1, 1'b0, 1'b1, 0, 1'b0, "R7");   // restart on final burst cycle
      cmdx(1'b1, 1'b1, 1'b0, 0, 1'b0, "R7");   // burst stop
      cmdx(1'b1, 1'b0, 1'b0, 0, 1'b0, "R7");   // WRITE
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b0, "R7");   // PRE during burst
      cmdx(1'b0, 1'b1, 1'b1, 0, 1'b0, "R6");   // ACT while closing
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b0, "R6");   // PRE on closing bank
      nops(1, "R6");
      // R8 auto-precharge
      cmdx(1'b0, 1'b1, 1'b1, 1, 1'b0, "R8");
      nops(2, "R8");
      cmdx(1'b1, 1'b0, 1'b1, 1, 1'b1, "R3");
      cmdx(1'b1, 1'b0, 1'b0, 1, 1'b0, "R8");
      cmdx(1'b0, 1'b1, 1'b0, 1, 1'b0, "R8");
      cmdx(1'b1, 1'b1, 1'b0, 1, 1'b0, "R8");
      nops(4, "R8");
      // R13 precharge-all
      cmdx(1'b0, 1'b1, 1'b1, 2, 1'b0, "R13");
      cmdx(1'b0, 1'b1, 1'b1, 3, 1'b0, "R13");
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b1, "R13");  // bank 3 still opening: illegal
      nops(1, "R13");
      cmdx(1'b1, 1'b0, 1'b0, 2, 1'b0, "R13");
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b1, "R3");   // legal precharge-all
      nops(2, "R13");
      // R5 refresh and mode set
      cmdx(1'b0, 1'b0, 1'b1, 0, 1'b0, "R5");
      nops(TRC, "R5");
      cmdx(1'b0, 1'b0, 1'b0, 0, 1'b0, "R5");
      nops(TRSC, "R5");
      // R9 self-refresh
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R9");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R9");
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R9");
      nops(TRC, "R9");
      // R10 clock suspend outside self-refresh
      cmdx(1'b0, 1'b1, 1'b1, 0, 1'b0, "R10");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R10");
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R10");
      // R2 remaining codes
      cmdx(1'b1, 1'b1, 1'b0, 0, 1'b0, "R2");
      cmdx(1'b0, 1'b1, 1'b0, 0, 1'b1, "R2");
      nops(3, "R2");
      // random mix
      for (int k = 0; k < 4000; k++) begin
         bit cs, kp, kc, a;
         logic [2:0] p;
         cs = ($urandom % 8) == 0;
         kp = ($urandom % 16) != 0;
         kc = ($urandom % 16) != 0;
         p = 3'($urandom);
         a = 1'($urandom);
         step(cs, p[2], p[1], p[0], kp, kc, int'($urandom % NB), a, "");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule